// File: doc/BRIEF.md
# Boundary-Scan Test Access Unit

This block is the test access port for a device under test. A serial test clock, a mode-select line and a serial data input drive a sixteen-state controller. The controller steps through instruction and data scan sequences, and the selected register is returned on a serial output. The block holds a three-bit instruction register and three data paths: a boundary chain of cells that sit between the core and its pins, a single bypass bit, and a 32-bit identification register.

Toward the core, the unit sees the pin input levels, the values the core wants to drive and the core's own drive enable. It returns the pin drive values and one drive enable. Under the external-test opcode, the pins are driven from a separate update stage of the boundary chain. Under the high-impedance opcode, every driven pin is floated. Under the other opcodes the core's values pass straight through. Boundary cells 0 to NIN-1 cover the input pins and sit nearest the serial output. Cells NIN to NIN+NOUT-1 cover the driven pins. The default is 297 cells.

Top module: `bscan_unit`

## Requirements
- R1: The controller follows the standard sixteen-state test-port graph. It advances only on the rising edge of `tck`, using the `tms` level sampled on that edge. This includes pausing a data scan and resuming it through the pause and exit-2 states without losing bits.
- R2: The controller reaches Test-Logic-Reset after five consecutive rising edges with `tms` high, from any state. It also reaches that state when `trst` is high at a rising edge (synchronous, active high).
- R3: The instruction register is 3 bits wide and shifts in least significant bit first. It loads 3'b001 in Capture-IR and takes the shifted value in Update-IR. It is forced to the identification opcode 3'b010 while `trst` is high and on any edge spent in Test-Logic-Reset.
- R4: The opcodes are 3'b000 external test, 3'b001 sample/preload, 3'b010 identification, 3'b011 high impedance and 3'b111 bypass. Values 3'b100 to 3'b110 act as bypass. The serial path length from `tdi` to `tdo` is NIN+NOUT, NIN+NOUT, 32, 1 and 1 bits respectively.
- R5: In Capture-DR under the identification opcode, the ID register loads `ID_CODE`, which then shifts out least significant bit first.
- R6: The bypass bit loads 0 in Capture-DR.
- R7: Under sample/preload, Capture-DR loads input cells from `pin_in` and driven cells from `core_out`. Throughout this opcode, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`.
- R8: The NOUT-bit update stage copies the driven-pin cells of the shift stage on the edge leaving Update-DR, and only under sample/preload or external test. Otherwise it holds its value.
- R9: Under external test, `pin_out` is the update stage and `pin_oe` is 1. Capture-DR loads input cells from `pin_in` and leaves the driven cells' shift contents unchanged.
- R10: Under the high-impedance opcode, `pin_oe` is 0 and the bypass bit is the scan path.
- R11: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only in Shift-DR and Shift-IR, and `tdo` presents the end bit of the selected register. Shift data moves from `tdi` toward `tdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | High while a shift state is active |
| pin_in | input | NIN | Levels on the input pins |
| core_out | input | NOUT | Values the core drives toward the pins |
| core_oe | input | 1 | Core drive enable |
| pin_out | output | NOUT | Values sent to the pins |
| pin_oe | output | 1 | Pin drive enable, low means floated |

## Verification
The bench builds the unit with its defaults: 137 input cells and 160 driven cells, giving the full 297-cell chain, and a 32-bit identification code. At that size, the path-length measurement for each of the eight opcodes separates the full chain from the 32-bit and 1-bit paths. Because the input and driven regions are both wide, patterns that differ in each region show a capture from the wrong source, or a boundary misplaced between the regions, in a single scan.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b010;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b011;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  // Fixed pattern loaded into the instruction shift stage in Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef struct packed {
    logic sel_bsr;   // boundary chain is the scan path
    logic sel_id;    // identification register is the scan path
    logic extest;    // pins driven from update stage
    logic highz;     // pins floated
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [IR_W-1:0] op);
    op_dec_t d;
    d = '0;
    case (op)
      OP_EXTEST: begin d.sel_bsr = 1'b1; d.extest = 1'b1; end
      OP_SAMPLE: d.sel_bsr = 1'b1;
      OP_IDCODE: d.sel_id  = 1'b1;
      OP_HIGHZ:  d.highz   = 1'b1;
      default:   d = '0;   // bypass and every unassigned value
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= nxt;
  end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_tdo
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck) begin
    if (trst) begin
      ir_sr <= '0;
    end else if (state == ST_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_SHF_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (trst || state == ST_TLR) ir_q <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_tdo = ir_sr[0];

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NIN  = 137,
  parameter int NOUT = 160
) (
  input  logic            tck,
  input  logic            trst,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic            sel,
  input  logic            extest,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  output logic            chain_tdo,
  output logic [NOUT-1:0] upd_q
);

  localparam int NCELL = NIN + NOUT;

  logic [NCELL-1:0] sr;
  logic [NCELL-1:0] cap_v;
  logic [NCELL-1:0] shift_v;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    if (i < NIN) begin : g_in
      assign cap_v[i] = pin_in[i];
    end else begin : g_out
      // driven cells keep their shift contents under external test
      assign cap_v[i] = extest ? sr[i] : core_out[i-NIN];
    end
    if (i == NCELL-1) begin : g_head
      assign shift_v[i] = tdi;
    end else begin : g_link
      assign shift_v[i] = sr[i+1];
    end
  end

  always_ff @(posedge tck) begin
    if (trst) begin
      sr <= '0;
    end else if (sel && state == ST_CAP_DR) begin
      sr <= cap_v;
    end else if (sel && state == ST_SHF_DR) begin
      sr <= shift_v;
    end
  end

  always_ff @(posedge tck) begin
    if (trst) begin
      upd_q <= '0;
    end else if (sel && state == ST_UPD_DR) begin
      upd_q <= sr[NCELL-1:NIN];
    end
  end

  assign chain_tdo = sr[0];

endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
  import bscan_pkg::*;
#(
  parameter int          NIN     = 137,
  parameter int          NOUT    = 160,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h2B7D_4E1F
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  input  logic            core_oe,
  output logic [NOUT-1:0] pin_out,
  output logic            pin_oe
);

  tap_state_e      st;
  logic [IR_W-1:0] ir_q;
  logic            ir_tdo;
  op_dec_t         dec;
  logic            chain_tdo;
  logic [NOUT-1:0] upd_q;
  logic            sel_byp;
  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  bscan_tap_fsm u_fsm (
    .tck   (tck),
    .trst  (trst),
    .tms   (tms),
    .state (st)
  );

  bscan_ir u_ir (
    .tck    (tck),
    .trst   (trst),
    .state  (st),
    .tdi    (tdi),
    .ir_q   (ir_q),
    .ir_tdo (ir_tdo)
  );

  assign dec     = decode_op(ir_q);
  assign sel_byp = !dec.sel_bsr && !dec.sel_id;

  bscan_chain #(.NIN(NIN), .NOUT(NOUT)) u_chain (
    .tck       (tck),
    .trst      (trst),
    .state     (st),
    .tdi       (tdi),
    .sel       (dec.sel_bsr),
    .extest    (dec.extest),
    .pin_in    (pin_in),
    .core_out  (core_out),
    .chain_tdo (chain_tdo),
    .upd_q     (upd_q)
  );

  // single bypass cell
  always_ff @(posedge tck) begin
    if (trst)                                byp_q <= 1'b0;
    else if (sel_byp && st == ST_CAP_DR)     byp_q <= 1'b0;
    else if (sel_byp && st == ST_SHF_DR)     byp_q <= tdi;
  end

  // identification register
  always_ff @(posedge tck) begin
    if (trst)                                id_sr <= '0;
    else if (dec.sel_id && st == ST_CAP_DR)  id_sr <= ID_CODE[ID_W-1:0];
    else if (dec.sel_id && st == ST_SHF_DR)  id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  // serial output, retimed to the falling edge
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == ST_SHF_DR) || (st == ST_SHF_IR);
      if (st == ST_SHF_IR)  tdo <= ir_tdo;
      else if (dec.sel_bsr) tdo <= chain_tdo;
      else if (dec.sel_id)  tdo <= id_sr[0];
      else                  tdo <= byp_q;
    end
  end

  // pin control
  always_comb begin
    pin_out = dec.extest ? upd_q : core_out;
    if (dec.highz)       pin_oe = 1'b0;
    else if (dec.extest) pin_oe = 1'b1;
    else                 pin_oe = core_oe;
  end

endmodule

// File: rtl/bscan_unit_chk.sv
module bscan_unit_chk
  import bscan_pkg::*;
#(
  parameter int NOUT = 160
) (
  input logic            tck,
  input logic            trst,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            byp,
  input logic [NOUT-1:0] upd,
  input logic [NOUT-1:0] core_out,
  input logic            core_oe,
  input logic [NOUT-1:0] pin_out,
  input logic            pin_oe,
  input logic            tdo_oe
);

  logic [2:0] hi_run;

  always_ff @(posedge tck) begin
    if (trst)              hi_run <= '0;
    else if (!tms)         hi_run <= '0;
    else if (hi_run != 5)  hi_run <= hi_run + 3'd1;
  end

  p_tlr_after_five_r2: assert property (@(posedge tck) disable iff (trst)
    (hi_run == 3'd5) |-> (state == ST_TLR));

  p_ir_reset_idcode_r3: assert property (@(posedge tck) disable iff (trst)
    (state == ST_TLR) |=> (ir == OP_IDCODE));

  p_bypass_cap_zero_r6: assert property (@(posedge tck) disable iff (trst)
    (state == ST_CAP_DR && ir != OP_EXTEST && ir != OP_SAMPLE && ir != OP_IDCODE)
      |=> (byp == 1'b0));

  p_sample_transparent_r7: assert property (@(posedge tck) disable iff (trst)
    (ir == OP_SAMPLE) |-> (pin_out == core_out && pin_oe == core_oe));

  p_upd_hold_r8: assert property (@(posedge tck) disable iff (trst)
    (state != ST_UPD_DR || ir[2:1] != 2'b00) |=> $stable(upd));

  p_highz_float_r10: assert property (@(posedge tck) disable iff (trst)
    (ir == OP_HIGHZ) |-> !pin_oe);

  p_tdo_en_shift_r11: assert property (@(posedge tck) disable iff (trst)
    tdo_oe == (state == ST_SHF_DR || state == ST_SHF_IR));

endmodule

bind bscan_unit bscan_unit_chk #(.NOUT(NOUT)) u_chk (
  .tck      (tck),
  .trst     (trst),
  .tms      (tms),
  .state    (st),
  .ir       (ir_q),
  .byp      (byp_q),
  .upd      (upd_q),
  .core_out (core_out),
  .core_oe  (core_oe),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .tdo_oe   (tdo_oe)
);

// File: tb/bscan_unit_tb.sv
`timescale 1ns/1ps
module bscan_unit_tb_top;

  localparam int          NIN   = 137;
  localparam int          NOUT  = 160;
  localparam int          NCELL = NIN + NOUT;
  localparam logic [31:0] IDV   = 32'h2B7D_4E1F;

  // {opcode[2:0], path length[9:0], expected pin_oe with core_oe=1}
  localparam logic [13:0] TBL [8] = '{
    {3'b000, 10'd297, 1'b1},
    {3'b001, 10'd297, 1'b1},
    {3'b010, 10'd32,  1'b1},
    {3'b011, 10'd1,   1'b0},
    {3'b100, 10'd1,   1'b1},
    {3'b101, 10'd1,   1'b1},
    {3'b110, 10'd1,   1'b1},
    {3'b111, 10'd1,   1'b1}
  };

  logic            tck = 1'b0;
  logic            trst = 1'b1;
  logic            tms = 1'b1;
  logic            tdi = 1'b0;
  logic            tdo, tdo_oe;
  logic [NIN-1:0]  pin_in = '0;
  logic [NOUT-1:0] core_out = '0;
  logic            core_oe = 1'b1;
  logic [NOUT-1:0] pin_out;
  logic            pin_oe;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic tdo_s, oe_s;

  always #2 tck = ~tck;

  bscan_unit #(.NIN(NIN), .NOUT(NOUT), .ID_W(32), .ID_CODE(IDV)) dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tdo_s = tdo; oe_s = tdo_oe; tms = m; tdi = d;
  endtask

  task automatic settle();
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      cap[i] = tdo_s;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0); settle();
  endtask

  task automatic shift_dr(input int n, input logic [511:0] din, output logic [511:0] dout);
    dout = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = tdo_s;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0); settle();
  endtask

  function automatic logic [511:0] pat(input int seed);
    logic [511:0] v;
    for (int i = 0; i < 512; i++) v[i] = (((i * seed) + (i / 5)) % 3) == 1;
    return v;
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]   cap;
    logic [511:0] rd, p, q;
    logic [511:0] a, b;
    int           found;

    repeat (3) @(posedge tck);
    @(negedge tck); trst = 1'b0;
    step(1'b0, 1'b0); settle();

    // reset state (R3, R11, R7 passthrough under default opcode)
    core_out = pat(5)[NOUT-1:0];
    #1;
    check("R11 tdo_oe idle after reset", 512'(tdo_oe), 512'(0));
    check("R3 reset opcode keeps pins transparent", 512'(pin_out), 512'(core_out));
    shift_dr(32, '0, rd);
    check("R5 R3 IDCODE after reset", 512'(rd[31:0]), 512'(IDV));

    // opcode table: capture pattern, pin enable, path length (R3 R4 R10 R11)
    core_oe = 1'b1;
    for (int e = 0; e < 8; e++) begin
      logic [2:0] op;
      int         len;
      op  = TBL[e][13:11];
      len = int'(TBL[e][10:1]);
      load_ir(op, cap);
      check($sformatf("R3 capture-IR pattern op %0d", op), 512'(cap), 512'(3'b001));
      check($sformatf("R10 R9 pin_oe op %0d", op), 512'(pin_oe), 512'(TBL[e][0]));
      step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int k = 0; k < 300; k++) step(1'b0, 1'b0);
      check($sformatf("R11 tdo_oe in shift op %0d", op), 512'(oe_s), 512'(1));
      step(1'b0, 1'b1);
      found = 0;
      for (int k = 1; k <= 310; k++) begin
        step(k == 310, 1'b0);
        if (tdo_s === 1'b1 && found == 0) found = k;
      end
      step(1'b1, 1'b0); step(1'b0, 1'b0); settle();
      check($sformatf("R4 path length op %0d", op), 512'(found), 512'(len));
      check($sformatf("R11 tdo_oe off after shift op %0d", op), 512'(tdo_oe), 512'(0));
    end

    // sample/preload (R7 R8)
    a = pat(7); b = pat(11); p = pat(13);
    pin_in = a[NIN-1:0]; core_out = b[NOUT-1:0]; core_oe = 1'b0;
    load_ir(3'b001, cap);
    check("R7 pins transparent under sample", 512'({pin_oe, pin_out}), 512'({core_oe, core_out}));
    shift_dr(NCELL, p, rd);
    check("R7 input cells capture pin_in", 512'(rd[NIN-1:0]), 512'(a[NIN-1:0]));
    check("R7 driven cells capture core_out", 512'(rd[NCELL-1:NIN]), 512'(b[NOUT-1:0]));
    check("R7 pins undisturbed after preload", 512'({pin_oe, pin_out}), 512'({core_oe, core_out}));

    // external test (R8 R9)
    load_ir(3'b000, cap);
    check("R8 R9 pins show preloaded update stage", 512'(pin_out), 512'(p[NCELL-1:NIN]));
    check("R9 pin_oe forced on", 512'(pin_oe), 512'(1));
    a = pat(17); q = pat(19);
    pin_in = a[NIN-1:0];
    shift_dr(NCELL, q, rd);
    check("R9 extest captures inputs", 512'(rd[NIN-1:0]), 512'(a[NIN-1:0]));
    check("R9 extest keeps driven shift cells", 512'(rd[NCELL-1:NIN]), 512'(p[NCELL-1:NIN]));
    check("R8 update under extest", 512'(pin_out), 512'(q[NCELL-1:NIN]));

    // bypass: capture 0, update stage untouched (R6 R8)
    load_ir(3'b111, cap);
    check("R4 bypass pins transparent", 512'(pin_out), 512'(core_out));
    shift_dr(2, 512'b11, rd);
    check("R6 bypass captures 0 then passes tdi", 512'(rd[1:0]), 512'(2'b10));
    shift_dr(1, 512'b1, rd);
    check("R6 bypass capture again 0", 512'(rd[0]), 512'(0));
    load_ir(3'b000, cap);
    check("R8 update stage held outside update", 512'(pin_out), 512'(q[NCELL-1:NIN]));

    // five TMS-high edges reach reset (R2)
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
    step(1'b0, 1'b0); settle();
    check("R2 five tms high returns to IDCODE", 512'({pin_oe, pin_out}), 512'({core_oe, core_out}));

    // paused data scan of the ID (R1 R11)
    rd = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 11; i++) begin
      step(i == 10, 1'b0);
      rd[i] = tdo_s;
    end
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R11 tdo_oe low in pause", 512'(oe_s), 512'(0));
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 11; i < 32; i++) begin
      step(i == 31, 1'b0);
      rd[i] = tdo_s;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0); settle();
    check("R1 ID intact across pause", 512'(rd[31:0]), 512'(IDV));

    // synchronous trst (R2)
    load_ir(3'b011, cap);
    check("R10 highz floats", 512'(pin_oe), 512'(0));
    @(negedge tck); trst = 1'b1;
    repeat (2) @(posedge tck);
    @(negedge tck); trst = 1'b0;
    step(1'b0, 1'b0); settle();
    check("R2 trst restores pin enable", 512'(pin_oe), 512'(core_oe));
    shift_dr(32, '0, rd);
    check("R2 R5 ID after trst", 512'(rd[31:0]), 512'(IDV));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule